// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter reached over a byte-wide register bus. Each count step comes from a tick source, either the system clock or a synchronized external count input, passed through a divide-by-1/2/4/8 prescaler. The block has a run bit, a sticky wrap flag with an interrupt enable, and an optional buffered mode. In buffered mode the high byte is read and written through a holding byte that moves on low-byte accesses, so software can read or load all 16 bits as one value.

A compare unit beside the timer gives its mode field and a 16-bit compare value. While that mode selects the trigger function and the count equals the compare value, the counter goes back to zero and a one-cycle conversion-start pulse is produced. The compare value then sets the period. The trigger never sets the wrap flag. A register write to the counter in the same cycle takes precedence over the trigger.

Register map, by 2-bit address: 0 = count low byte, 1 = count high byte, 2 = control, 3 = status. Control bits: 7 buffered mode, 6 unused (reads 0), 5:4 prescale select, 3 oscillator enable (stored only), 2 sync select (stored only), 1 tick source (1 = external), 0 run. Status bits: 0 wrap flag, 1 interrupt enable, 7:2 read 0.

Top module: `tmr16_unit`

## Requirements
- R1: With source bit 0 and prescale 0, the count rises by one on each clock edge at which the run bit is already set. It does not change while run is clear. It wraps from 0xFFFF to 0x0000.
- R2: Prescale select value p (control bits 5:4) makes the count advance once per 2^p source ticks.
- R3: A wrap sets status bit 0. The bit stays set until a status write stores a new value in it. irq is high exactly when status bits 0 and 1 are both 1.
- R4: Control reads back what was written, with bit 6 always 0.
- R5: With buffered mode off, address 1 reads and writes the live count high byte, and a write to address 0 changes only the low byte.
- R6: With buffered mode on, a read of address 0 copies the live high byte into the holding byte. Reads of address 1 return the holding byte.
- R7: With buffered mode on, a write to address 1 changes only the holding byte. A write to address 0 loads {holding byte, data} into the count at once.
- R8: A write to address 0 clears the prescaler. A write to address 1 leaves it untouched.
- R9: With the compare mode at 4'b1011 and the count equal to the compare value, the next edge sets the count to 0 and raises adc_start for that one cycle. Any other mode value gives no trigger.
- R10: The trigger never sets the wrap flag. A trigger and a wrap in the same cycle leave the count at 0 with the flag clear.
- R11: A counter write in a trigger cycle wins: the written value is stored and adc_start stays low.
- R12: With source bit 1, each rising edge on ext_cnt_in, after a two-flop synchronizer, is one source tick. The system clock alone does not advance the count.
- R13: After reset, all registers read 0, and irq and adc_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_cnt_in | input | 1 | External count input |
| cmp_mode | input | 4 | Compare unit mode field |
| cmp_val | input | 16 | Compare (period) value |
| irq | output | 1 | Wrap interrupt request |
| adc_start | output | 1 | Conversion-start pulse |

## Verification
Writes, count steps, trigger resets and flag updates show at the edge that takes the strobe. The read mux is combinational, so a value is due as soon as the next edge has passed. The bench drives at the falling edge and samples read data 1 ns later. Each run window is opened and closed by control writes, so the number of counting edges is exact: a count is due one edge after the run bit is registered, and the closing write's edge still counts. An external edge takes three clock edges to reach the prescaler, and the bench waits well past that before reading.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  localparam int CB_BUF  = 7;
  localparam int CB_PSLO = 4;
  localparam int CB_SRC  = 1;
  localparam int CB_RUN  = 0;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hBF;

  localparam int SB_FLAG = 0;
  localparam int SB_IE   = 1;

  localparam logic [MODE_W-1:0] TRIG_MODE = 4'b1011;
endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick #(
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_ext,
  input  logic            ext_in,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            pre_clr,
  output logic            tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [PRE_W-1:0]       pre_q, pre_d;
  logic                   rise, src_pulse, pre_hit;
  logic [PRE_W-1:0]       mask;

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], ext_in};
    prev_d    = sync_q[SYNC_STAGES-1];
    rise      = sync_q[SYNC_STAGES-1] & ~prev_q;
    src_pulse = src_ext ? rise : 1'b1;
    mask      = ~({PRE_W{1'b1}} << ps_sel);
    pre_hit   = ((pre_q & mask) == mask);
    tick      = run && src_pulse && pre_hit;
    if (pre_clr)                pre_d = '0;
    else if (run && src_pulse)  pre_d = pre_hit ? '0 : pre_q + PRE_W'(1);
    else                        pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pre_q  <= pre_d;
    end
  end

  a_r12_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps_sel != '0 && !pre_clr) |=> (!tick || ps_sel == '0));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wdata,
  input  logic [BW-1:0]   hi_load,
  input  logic [MODE_W-1:0] cmp_mode,
  input  logic [2*BW-1:0] cmp_val,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic [2*BW-1:0] cnt_q,
  output logic            flag_q,
  output logic            adc_start
);
  localparam int CNT_W = 2 * BW;

  logic [CNT_W-1:0] cnt_d;
  logic             flag_d, adc_d;
  logic             cnt_wr, trig_match, trig_fire, wrap;

  always_comb begin
    cnt_wr     = wr_lo | wr_hi;
    trig_match = (cmp_mode == TRIG_MODE) && (cnt_q == cmp_val);
    trig_fire  = trig_match && !cnt_wr;
    wrap       = inc && (cnt_q == {CNT_W{1'b1}}) && !cnt_wr && !trig_fire;
    if (wr_lo)          cnt_d = {hi_load, wdata};
    else if (wr_hi)     cnt_d = {wdata, cnt_q[BW-1:0]};
    else if (trig_fire) cnt_d = '0;
    else if (inc)       cnt_d = cnt_q + CNT_W'(1);
    else                cnt_d = cnt_q;
    if (wrap)           flag_d = 1'b1;
    else if (flag_wr)   flag_d = flag_wdata;
    else                flag_d = flag_q;
    adc_d = trig_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      flag_q    <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      flag_q    <= flag_d;
      adc_start <= adc_d;
    end
  end

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && !trig_match) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
  a_r9_trig_reset: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (cnt_q == '0 && adc_start));
  a_r10_no_flag_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_match && !flag_wr && !flag_q) |=> !flag_q);
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_match && cnt_wr) |=> !adc_start);
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_wr) |=> flag_q);
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                ext_cnt_in,
  input  logic [MODE_W-1:0]   cmp_mode,
  input  logic [2*BYTE_W-1:0] cmp_val,
  output logic                irq,
  output logic                adc_start
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d, hbuf_q, hbuf_d;
  logic              ie_q, ie_d;
  logic [CNT_W-1:0]  cnt;
  logic              flag;
  logic              tick, buf_mode;
  logic              wr_lo, wr_hi_any, rd_lo, wr_ctrl, wr_stat;
  logic              core_wr_hi;
  logic [BYTE_W-1:0] hi_load;
  logic [BYTE_W-1:0] cnt_hi, cnt_lo;

  assign cnt_hi = cnt[CNT_W-1:BYTE_W];
  assign cnt_lo = cnt[BYTE_W-1:0];

  always_comb begin
    buf_mode   = ctrl_q[CB_BUF];
    wr_lo      = bus_wr && (bus_addr == A_CNT_LO);
    wr_hi_any  = bus_wr && (bus_addr == A_CNT_HI);
    rd_lo      = bus_rd && (bus_addr == A_CNT_LO);
    wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
    wr_stat    = bus_wr && (bus_addr == A_STAT);
    core_wr_hi = wr_hi_any && !buf_mode;
    hi_load    = buf_mode ? hbuf_q : cnt_hi;

    ctrl_d = wr_ctrl ? (bus_wdata & CTRL_MASK) : ctrl_q;
    ie_d   = wr_stat ? bus_wdata[SB_IE] : ie_q;
    if (buf_mode && wr_hi_any)  hbuf_d = bus_wdata;
    else if (buf_mode && rd_lo) hbuf_d = cnt_hi;
    else                        hbuf_d = hbuf_q;

    unique case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_lo;
      A_CNT_HI: bus_rdata = buf_mode ? hbuf_q : cnt_hi;
      A_CTRL:   bus_rdata = ctrl_q;
      default:  begin
        bus_rdata          = '0;
        bus_rdata[SB_FLAG] = flag;
        bus_rdata[SB_IE]   = ie_q;
      end
    endcase
    irq = flag && ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hbuf_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      hbuf_q <= hbuf_d;
      ie_q   <= ie_d;
    end
  end

  tmr16_tick #(.SYNC_STAGES(SYNC_STAGES), .PS_W(PS_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[CB_RUN]),
    .src_ext (ctrl_q[CB_SRC]),
    .ext_in  (ext_cnt_in),
    .ps_sel  (ctrl_q[CB_PSLO +: PS_W]),
    .pre_clr (wr_lo),
    .tick    (tick)
  );

  tmr16_core #(.BW(BYTE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (tick),
    .wr_lo      (wr_lo),
    .wr_hi      (core_wr_hi),
    .wdata      (bus_wdata),
    .hi_load    (hi_load),
    .cmp_mode   (cmp_mode),
    .cmp_val    (cmp_val),
    .flag_wr    (wr_stat),
    .flag_wdata (bus_wdata[SB_FLAG]),
    .cnt_q      (cnt),
    .flag_q     (flag),
    .adc_start  (adc_start)
  );

  a_r7_buf_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_hi_any && !ctrl_q[CB_RUN] && cmp_mode != TRIG_MODE)
      |=> cnt_hi == $past(cnt_hi));
  a_r6_read_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && rd_lo && !bus_wr) |=> hbuf_q == $past(cnt_hi));
  a_r4_bit6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !ctrl_q[6]);
endmodule

// File: tb/tb_tmr16_unit.sv
`timescale 1ns/1ps
module tb_tmr16_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        ext_cnt_in;
  logic [3:0]  cmp_mode;
  logic [15:0] cmp_val;
  logic        irq, adc_start;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  event smp_ev;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  tmr16_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_cnt_in(ext_cnt_in), .cmp_mode(cmp_mode), .cmp_val(cmp_val),
    .irq(irq), .adc_start(adc_start)
  );

  // monitor: pops expected read data and compares
  always @(smp_ev) begin
    exp_t it;
    it = exp_q.pop_front();
    n_chk++;
    if (bus_rdata !== it.val) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.val);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(it);
    #1;
    -> smp_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, e);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ext_cnt_in = 0; cmp_mode = 0; cmp_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk(irq, 1'b0, "R13 irq");
    chk(adc_start, 1'b0, "R13 adc_start");
    rd(2, 8'h00, "R13 ctrl"); rd(0, 8'h00, "R13 lo");
    rd(1, 8'h00, "R13 hi");   rd(3, 8'h00, "R13 stat");

    // R4 control readback, bit 6 zero
    wr(2, 8'hFE); rd(2, 8'hBE, "R4 ctrl bit6"); wr(2, 8'h00);

    // R5 direct high byte
    wr(1, 8'h12); wr(0, 8'h34);
    rd(0, 8'h34, "R5 lo"); rd(1, 8'h12, "R5 hi");

    // R1 counting window of five edges
    wr(1, 0); wr(0, 0); wr(2, 8'h01); idle(4); wr(2, 8'h00);
    rd(0, 8'h05, "R1 count"); rd(1, 8'h00, "R1 hi");

    // R2 prescale by 4 and by 8
    wr(0, 0); wr(2, 8'h21); idle(7); wr(2, 8'h20);
    rd(0, 8'h02, "R2 div4");
    wr(0, 0); wr(2, 8'h31); idle(15); wr(2, 8'h30);
    rd(0, 8'h02, "R2 div8");

    // R8 high write keeps prescaler, low write clears it
    wr(0, 0); wr(2, 8'h11); wr(2, 8'h10); wr(1, 8'h00);
    wr(2, 8'h11); wr(2, 8'h10);
    rd(0, 8'h01, "R8 hi write keeps prescaler");
    wr(0, 0); wr(2, 8'h11); wr(2, 8'h10); wr(0, 8'h00);
    wr(2, 8'h11); wr(2, 8'h10);
    rd(0, 8'h00, "R8 lo write clears prescaler");

    // R7 / R6 buffered access
    wr(2, 8'h00); wr(1, 0); wr(0, 0);
    wr(2, 8'h80); wr(1, 8'hAB); rd(1, 8'hAB, "R7 buffer read");
    wr(2, 8'h00); rd(1, 8'h00, "R7 counter hi untouched");
    wr(2, 8'h80); wr(0, 8'hCD); wr(2, 8'h00);
    rd(1, 8'hAB, "R7 atomic hi"); rd(0, 8'hCD, "R7 atomic lo");
    wr(2, 8'h80); wr(1, 8'h55); rd(1, 8'h55, "R6 buffer not live");
    rd(0, 8'hCD, "R6 lo read"); rd(1, 8'hAB, "R6 latched hi");

    // R3 / R1 wrap and flag
    wr(2, 8'h00); wr(1, 8'hFF); wr(0, 8'hFE); wr(3, 8'h02);
    wr(2, 8'h01); wr(2, 8'h00);
    rd(3, 8'h02, "R3 no flag at FFFF"); chk(irq, 1'b0, "R3 irq before wrap");
    wr(2, 8'h01); wr(2, 8'h00);
    rd(3, 8'h03, "R3 flag on wrap"); chk(irq, 1'b1, "R3 irq on wrap");
    rd(0, 8'h00, "R1 wrap lo"); rd(1, 8'h00, "R1 wrap hi");
    idle(3); rd(3, 8'h03, "R3 sticky");
    wr(3, 8'h02); rd(3, 8'h02, "R3 clear"); chk(irq, 1'b0, "R3 irq cleared");
    wr(3, 8'h01); rd(3, 8'h01, "R3 flag no enable"); chk(irq, 1'b0, "R3 irq gated");
    wr(3, 8'h00);

    // R9 trigger as period
    wr(1, 0); wr(0, 0); cmp_val = 16'h0003; cmp_mode = 4'b1011;
    wr(2, 8'h01); idle(3); idle(1);
    chk(adc_start, 1'b1, "R9 adc pulse");
    wr(2, 8'h00);
    chk(adc_start, 1'b0, "R9 pulse one cycle");
    rd(0, 8'h01, "R9 reset then count"); rd(3, 8'h00, "R10 no flag");
    cmp_mode = 4'b1010; wr(1, 0); wr(0, 8'h03); idle(2);
    chk(adc_start, 1'b0, "R9 other mode no pulse");
    rd(0, 8'h03, "R9 other mode no reset");

    // R11 write wins over trigger
    cmp_val = 16'h0005; wr(0, 8'h05);
    cmp_mode = 4'b1011; wr(0, 8'h09);
    chk(adc_start, 1'b0, "R11 adc suppressed");
    rd(0, 8'h09, "R11 write value kept");

    // R10 trigger beats wrap
    cmp_mode = 4'b1010; cmp_val = 16'hFFFF;
    wr(1, 8'hFF); wr(0, 8'hFF); wr(2, 8'h01);
    cmp_mode = 4'b1011; wr(2, 8'h00);
    chk(adc_start, 1'b1, "R10 trigger at FFFF");
    rd(3, 8'h00, "R10 flag clear"); rd(0, 8'h00, "R10 lo"); rd(1, 8'h00, "R10 hi");
    cmp_mode = 4'b0000;

    // R12 external source
    wr(1, 0); wr(0, 0); wr(2, 8'h03);
    for (int i = 0; i < 3; i++) begin
      ext_cnt_in = 1'b1; idle(4);
      ext_cnt_in = 1'b0; idle(4);
    end
    idle(4); wr(2, 8'h02);
    rd(0, 8'h03, "R12 external edges"); rd(1, 8'h00, "R12 hi");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule